// File: doc/BRIEF.md
# Secure key register controller

This block keeps a secret key in a small bank of 32-bit registers behind a simple memory-mapped read and write port. Eight key words make up a 256-bit key, and a ninth auxiliary word sits next to them. The key words never read back. They can be changed only after software writes a fixed unlock value into the program-mode register. That write wipes the key and arms programming mode, and only reset leaves the mode again.

Once the key is loaded, software writes its own checksum of the key into the checksum register. The block then runs a sequential CRC over one leading zero word and the eight key words, at one word per clock. When the CRC finishes, status reports that the check is done and whether the checksum matched. Software can wipe the key at any time through the control register.

A single interrupt line comes from a one-bit event register with a mask. An external fault pulse sets the event bit. Reset returns every control and status register to its initial value but leaves the key storage untouched. The auxiliary word is built in one of two ways, chosen by a parameter: write-only and wiped along with the key, or readable and protected by a sticky lock.

Top module: `key_vault_ctrl`

## Requirements
- R1: After reset the status register at 0x00 reads 0, the event register at 0x38 reads 0, the mask at 0x3C reads 1, the lock at 0x4C reads 0, and irq is low.
- R2: Writing exactly 0x757BDF0D to 0x08 wipes the key and sets status bit 0 (programming mode) and status bit 4 (zeroized). Any other value written there changes nothing. Once set, status bit 0 stays set until reset, even if 0x08 is written again with another value.
- R3: Reads of the key words at 0x10 to 0x2C and of the checksum register at 0x0C always return 0.
- R4: Writing 1 to bit 0 of the control register at 0x04 wipes the key and sets status bit 4. A read of 0x04 always returns 0.
- R5: A wipe clears key words 0 to 7. It clears the auxiliary word only in the write-only configuration; in the lockable configuration that word keeps its value.
- R6: An accepted nonzero write to a key word clears status bit 4. A write to the auxiliary word at 0x30 affects status bit 4 only in the write-only configuration.
- R7: The auxiliary word at 0x30 accepts a write only while programming mode is set and the lock is clear. In the write-only configuration it reads 0; in the lockable configuration it reads back its stored value.
- R8: Writing 1 to bit 0 of 0x4C sets the lock. Writing 0 does not clear it; only reset does. In the write-only configuration the lock can never be set.
- R9: In programming mode, a write to 0x0C clears status bits 8 and 9 and starts a CRC. The CRC is reflected, uses polynomial 0x82F63B78, starts from 0xFFFFFFFF and has no final inversion. It runs over a zero word and then key words 0 to 7 in order, each word least significant bit first. On the ninth clock edge after the write, bit 8 (done) is set, and bit 9 (pass) is set if the CRC equals the written value. Outside programming mode a write to 0x0C has no effect.
- R10: A write to 0x0C while a CRC is still running throws that run away and restarts the check against the newly written value.
- R11: A fault_evt pulse sets bit 0 of 0x38, and writing 1 to that bit clears it. If a fault and a clear arrive in the same cycle, the set wins. Writing 1 to bit 0 of 0x40 clears the mask, and writing 1 to bit 0 of 0x44 sets it. Direct writes to 0x3C are ignored. irq is high exactly when the event bit is 1 and the mask is 0.
- R12: Reset returns all control and status registers to their R1 values but keeps the stored key and auxiliary words.
- R13: Bit 0 of the error-enable register at 0x34 can be written and read back. All other bits of that register read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe; rdata is valid after the next edge |
| addr | input | ADDR_W | Byte address; must be word aligned |
| wdata | input | 32 | Write data |
| fault_evt | input | 1 | Fault pulse that sets the event bit |
| rdata | output | 32 | Registered read data |
| irq | output | 1 | Registered interrupt, high while the event bit is set and unmasked |

## Verification
Two pairs of functions can land on the same clock edge. The first pair is the hardware fault pulse and a software write-one-to-clear of the event bit. The bench drives both in one cycle and then expects the event bit and irq to remain set. The second pair is a CRC that is still running and a fresh checksum write. The bench issues the second write four cycles after the first, reads status at the edge where the old run would have finished and expects done still clear, and then expects a pass from the new value. A behavioural model runs beside both configurations and is compared with rdata and irq on every clock.

// File: rtl/kv_pkg.sv
package kv_pkg;
  localparam int unsigned WORD_W = 32;
  localparam logic [31:0] PGM_MAGIC = 32'h757B_DF0D;
  localparam logic [31:0] CRC_POLY  = 32'h82F6_3B78;
  localparam logic [31:0] CRC_SEED  = 32'hFFFF_FFFF;

  // word offsets (byte address / 4)
  localparam int unsigned OFS_STATUS = 0;
  localparam int unsigned OFS_CTRL   = 1;
  localparam int unsigned OFS_PGM    = 2;
  localparam int unsigned OFS_CHK    = 3;
  localparam int unsigned OFS_KEY0   = 4;
  localparam int unsigned OFS_ERREN  = 13;
  localparam int unsigned OFS_EVT    = 14;
  localparam int unsigned OFS_MASK   = 15;
  localparam int unsigned OFS_UNMASK = 16;
  localparam int unsigned OFS_DOMASK = 17;
  localparam int unsigned OFS_LOCK   = 19;

  // status bit positions
  localparam int unsigned ST_PGM  = 0;
  localparam int unsigned ST_ZERO = 4;
  localparam int unsigned ST_DONE = 8;
  localparam int unsigned ST_PASS = 9;

  // fold one word into a reflected CRC, 32 shift steps in one call
  function automatic logic [31:0] crc_fold(input logic [31:0] acc, input logic [31:0] w);
    logic [31:0] c;
    c = acc ^ w;
    for (int b = 0; b < 32; b++) begin
      c = c[0] ? ((c >> 1) ^ CRC_POLY) : (c >> 1);
    end
    return c;
  endfunction
endpackage

// File: rtl/kv_key_bank.sv
module kv_key_bank #(
  parameter int unsigned NKEY   = 8,
  parameter int unsigned DW     = 32,
  parameter bit          AUX_WO = 1'b1,
  parameter int unsigned SW     = (NKEY > 1) ? $clog2(NKEY) : 1
) (
  input  logic                      clk,
  input  logic                      wr_key,
  input  logic [SW-1:0]             wr_idx,
  input  logic                      wr_aux,
  input  logic [DW-1:0]             wdata,
  input  logic                      allow_key,
  input  logic                      allow_aux,
  input  logic                      zeroize,
  output logic [NKEY-1:0][DW-1:0]   key_words,
  output logic [DW-1:0]             aux_word,
  output logic                      clr_zero_flag
);
  logic [DW-1:0] key_q [NKEY];
  logic [DW-1:0] aux_q;
  logic          key_take, aux_take;

  assign key_take = wr_key && allow_key;
  assign aux_take = wr_aux && allow_aux;

  // storage has no reset: it survives a reset of the register file
  for (genvar i = 0; i < NKEY; i++) begin : g_word
    always_ff @(posedge clk) begin
      if (zeroize)
        key_q[i] <= '0;
      else if (key_take && wr_idx == SW'(i))
        key_q[i] <= wdata;
    end
    assign key_words[i] = key_q[i];
  end

  always_ff @(posedge clk) begin
    if (zeroize && AUX_WO)
      aux_q <= '0;
    else if (aux_take)
      aux_q <= wdata;
  end
  assign aux_word = aux_q;

  always_comb begin
    clr_zero_flag = key_take && (|wdata);
    if (AUX_WO && aux_take && (|wdata))
      clr_zero_flag = 1'b1;
  end
endmodule

// File: rtl/kv_crc_seq.sv
module kv_crc_seq
  import kv_pkg::*;
#(
  parameter int unsigned NKEY = 8,
  parameter int unsigned IW   = $clog2(NKEY + 1)
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          start,
  input  logic [WORD_W-1:0]             expect_val,
  input  logic [NKEY-1:0][WORD_W-1:0]   key_words,
  output logic                          busy,
  output logic                          done,
  output logic                          pass
);
  logic [IW-1:0]     idx;
  logic [WORD_W-1:0] acc, acc_n, ref_q, cur_word;

  // step 0 feeds the leading zero word, step n feeds key word n-1
  always_comb begin
    cur_word = '0;
    for (int i = 0; i < NKEY; i++) begin
      if (32'(idx) == i + 1) cur_word = key_words[i];
    end
    acc_n = crc_fold(acc, cur_word);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      done  <= 1'b0;
      pass  <= 1'b0;
      idx   <= '0;
      acc   <= CRC_SEED;
      ref_q <= '0;
    end else if (start) begin
      busy  <= 1'b1;
      done  <= 1'b0;
      pass  <= 1'b0;
      idx   <= '0;
      acc   <= CRC_SEED;
      ref_q <= expect_val;
    end else if (busy) begin
      acc <= acc_n;
      if (32'(idx) == NKEY) begin
        busy <= 1'b0;
        done <= 1'b1;
        pass <= (acc_n == ref_q);
      end else begin
        idx <= idx + 1'b1;
      end
    end
  end
endmodule

// File: rtl/kv_irq_ctl.sv
module kv_irq_ctl (
  input  logic clk,
  input  logic rst,
  input  logic fault_evt,
  input  logic evt_clr,
  input  logic mask_clr,
  input  logic mask_set,
  output logic isr_q,
  output logic imr_q,
  output logic irq
);
  logic isr_n, imr_n;

  always_comb begin
    isr_n = fault_evt | (isr_q & ~evt_clr);
    imr_n = imr_q;
    if (mask_set)      imr_n = 1'b1;
    else if (mask_clr) imr_n = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      isr_q <= 1'b0;
      imr_q <= 1'b1;
      irq   <= 1'b0;
    end else begin
      isr_q <= isr_n;
      imr_q <= imr_n;
      irq   <= isr_n & ~imr_n;
    end
  end
endmodule

// File: rtl/key_vault_ctrl.sv
module key_vault_ctrl
  import kv_pkg::*;
#(
  parameter int unsigned ADDR_W = 7,
  parameter int unsigned NKEY   = 8,
  parameter bit          AUX_WO = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  input  logic              fault_evt,
  output logic [31:0]       rdata,
  output logic              irq
);
  localparam int unsigned SW      = (NKEY > 1) ? $clog2(NKEY) : 1;
  localparam int unsigned OFS_AUX = OFS_KEY0 + NKEY;

  int unsigned wsel;
  logic        aligned;
  assign wsel    = 32'(addr[ADDR_W-1:2]);
  assign aligned = (addr[1:0] == 2'b00);

  logic wr_ctrl, wr_pgm, wr_chk, wr_key, wr_aux, wr_erren;
  logic wr_evt, wr_unmask, wr_domask, wr_lock;
  logic [SW-1:0] key_idx;

  always_comb begin
    wr_ctrl   = wr_en && aligned && (wsel == OFS_CTRL);
    wr_pgm    = wr_en && aligned && (wsel == OFS_PGM);
    wr_chk    = wr_en && aligned && (wsel == OFS_CHK);
    wr_key    = wr_en && aligned && (wsel >= OFS_KEY0) && (wsel < OFS_AUX);
    wr_aux    = wr_en && aligned && (wsel == OFS_AUX);
    wr_erren  = wr_en && aligned && (wsel == OFS_ERREN);
    wr_evt    = wr_en && aligned && (wsel == OFS_EVT);
    wr_unmask = wr_en && aligned && (wsel == OFS_UNMASK);
    wr_domask = wr_en && aligned && (wsel == OFS_DOMASK);
    wr_lock   = wr_en && aligned && (wsel == OFS_LOCK);
    key_idx   = SW'(wsel - OFS_KEY0);
  end

  logic pgm_q, zero_q, lock_q, erren_q;
  logic magic_hit, zeroize;
  assign magic_hit = wr_pgm && (wdata == PGM_MAGIC);
  assign zeroize   = (wr_ctrl && wdata[0]) || magic_hit;

  logic [NKEY-1:0][31:0] key_words;
  logic [31:0]           aux_word;
  logic                  clr_zero_flag;

  kv_key_bank #(
    .NKEY  (NKEY),
    .DW    (WORD_W),
    .AUX_WO(AUX_WO),
    .SW    (SW)
  ) u_key_bank (
    .clk          (clk),
    .wr_key       (wr_key),
    .wr_idx       (key_idx),
    .wr_aux       (wr_aux),
    .wdata        (wdata),
    .allow_key    (pgm_q),
    .allow_aux    (pgm_q && !lock_q),
    .zeroize      (zeroize),
    .key_words    (key_words),
    .aux_word     (aux_word),
    .clr_zero_flag(clr_zero_flag)
  );

  logic crc_busy, crc_done, crc_pass;

  kv_crc_seq #(.NKEY(NKEY)) u_crc (
    .clk       (clk),
    .rst       (rst),
    .start     (wr_chk && pgm_q),
    .expect_val(wdata),
    .key_words (key_words),
    .busy      (crc_busy),
    .done      (crc_done),
    .pass      (crc_pass)
  );

  logic isr_q, imr_q;

  kv_irq_ctl u_irq (
    .clk      (clk),
    .rst      (rst),
    .fault_evt(fault_evt),
    .evt_clr  (wr_evt && wdata[0]),
    .mask_clr (wr_unmask && wdata[0]),
    .mask_set (wr_domask && wdata[0]),
    .isr_q    (isr_q),
    .imr_q    (imr_q),
    .irq      (irq)
  );

  // control and status flags
  always_ff @(posedge clk) begin
    if (rst) begin
      pgm_q   <= 1'b0;
      zero_q  <= 1'b0;
      lock_q  <= 1'b0;
      erren_q <= 1'b0;
    end else begin
      if (magic_hit) pgm_q <= 1'b1;
      if (zeroize)            zero_q <= 1'b1;
      else if (clr_zero_flag) zero_q <= 1'b0;
      if (wr_lock && wdata[0] && !AUX_WO) lock_q <= 1'b1;
      if (wr_erren) erren_q <= wdata[0];
    end
  end

  logic [31:0] status_word, rd_val;

  always_comb begin
    status_word          = '0;
    status_word[ST_PGM]  = pgm_q;
    status_word[ST_ZERO] = zero_q;
    status_word[ST_DONE] = crc_done;
    status_word[ST_PASS] = crc_pass;
  end

  always_comb begin
    rd_val = '0;
    if (aligned) begin
      case (wsel)
        OFS_STATUS: rd_val = status_word;
        OFS_AUX:    rd_val = AUX_WO ? '0 : aux_word;
        OFS_ERREN:  rd_val = {31'b0, erren_q};
        OFS_EVT:    rd_val = {31'b0, isr_q};
        OFS_MASK:   rd_val = {31'b0, imr_q};
        OFS_LOCK:   rd_val = {31'b0, lock_q};
        default:    rd_val = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_val;
  end
endmodule

// File: rtl/kv_checker.sv
module kv_checker #(
  parameter int unsigned ADDR_W = 7,
  parameter int unsigned NKEY   = 8,
  parameter bit          AUX_WO = 1'b1
) (
  input logic              clk,
  input logic              rst,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [31:0]       rdata,
  input logic              fault_evt,
  input logic              isr,
  input logic              imr,
  input logic              irq,
  input logic              pgm,
  input logic              lock,
  input logic              crc_busy,
  input logic              crc_done
);
  localparam int unsigned KEY_LO = 16;
  localparam int unsigned KEY_HI = 16 + 4 * NKEY;

  assert_pgm_sticky_R2: assert property (@(posedge clk) disable iff (rst)
    pgm |=> pgm);

  assert_key_read_zero_R3: assert property (@(posedge clk) disable iff (rst)
    (rd_en && 32'(addr) >= KEY_LO && 32'(addr) < KEY_HI) |=> (rdata == 32'd0));

  assert_chk_read_zero_R3: assert property (@(posedge clk) disable iff (rst)
    (rd_en && 32'(addr) == 32'd12) |=> (rdata == 32'd0));

  assert_ctrl_read_zero_R4: assert property (@(posedge clk) disable iff (rst)
    (rd_en && 32'(addr) == 32'd4) |=> (rdata == 32'd0));

  assert_lock_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    lock |=> lock);

  assert_lock_never_wo_R8: assert property (@(posedge clk) disable iff (rst)
    AUX_WO |-> !lock);

  assert_done_after_run_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(crc_done) |-> $past(crc_busy));

  assert_fault_sets_evt_R11: assert property (@(posedge clk) disable iff (rst)
    fault_evt |=> isr);

  assert_irq_tracks_R11: assert property (@(posedge clk) disable iff (rst)
    irq == (isr && !imr));
endmodule

bind key_vault_ctrl kv_checker #(
  .ADDR_W(ADDR_W),
  .NKEY  (NKEY),
  .AUX_WO(AUX_WO)
) u_kv_checker (
  .clk      (clk),
  .rst      (rst),
  .rd_en    (rd_en),
  .addr     (addr),
  .rdata    (rdata),
  .fault_evt(fault_evt),
  .isr      (isr_q),
  .imr      (imr_q),
  .irq      (irq),
  .pgm      (pgm_q),
  .lock     (lock_q),
  .crc_busy (crc_busy),
  .crc_done (crc_done)
);

// File: tb/test_key_vault_ctrl.sv
module test_key_vault_ctrl;
  logic        clk = 1'b0, rst = 1'b1, wr_en = 1'b0, rd_en = 1'b0, fault_evt = 1'b0;
  logic [6:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata0, rdata1;
  logic        irq0, irq1;

  always #5 clk = ~clk;

  // write-only auxiliary word (default) and lockable auxiliary word
  key_vault_ctrl i_key_vault_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .fault_evt(fault_evt), .rdata(rdata0), .irq(irq0));
  key_vault_ctrl #(.AUX_WO(1'b0)) i_key_vault_ctrl_lk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .fault_evt(fault_evt), .rdata(rdata1), .irq(irq1));

  int    errors = 0, checks = 0;
  string cur_req = "R1";
  bit    cmp_on = 1'b0, finished = 1'b0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [31:0] m_key [2][9];
  bit          m_pgm [2], m_zed [2], m_done [2], m_pass [2], m_lock [2];
  bit          m_err [2], m_isr [2], m_imr [2], m_irq [2];
  int          m_cnt [2];
  logic [31:0] m_exp [2], m_cap [2], m_rd [2];

  initial begin
    for (int k = 0; k < 2; k++)
      for (int w = 0; w < 9; w++) m_key[k][w] = '0;
  end

  function automatic logic [31:0] crc_of(input logic [255:0] flat);
    logic [31:0] c;
    bit          fb;
    c = 32'hFFFF_FFFF;
    for (int b = 0; b < 32; b++) begin
      fb = c[0];
      c  = c >> 1;
      if (fb) c = c ^ 32'h82F6_3B78;
    end
    for (int n = 0; n < 8; n++) begin
      for (int b = 0; b < 32; b++) begin
        fb = c[0] ^ flat[32*n + b];
        c  = c >> 1;
        if (fb) c = c ^ 32'h82F6_3B78;
      end
    end
    return c;
  endfunction

  function automatic logic [31:0] m_read(input int k, input int a);
    case (a)
      'h00: return {22'b0, m_pass[k], m_done[k], 3'b0, m_zed[k], 3'b0, m_pgm[k]};
      'h30: return (k == 0) ? 32'd0 : m_key[k][8];
      'h34: return {31'b0, m_err[k]};
      'h38: return {31'b0, m_isr[k]};
      'h3C: return {31'b0, m_imr[k]};
      'h4C: return {31'b0, m_lock[k]};
      default: return 32'd0;
    endcase
  endfunction

  task automatic m_wipe(input int k);
    for (int w = 0; w < 8; w++) m_key[k][w] = '0;
    if (k == 0) m_key[k][8] = '0;
    m_zed[k] = 1'b1;
  endtask

  task automatic m_step(input int k);
    int          a;
    bit          nisr;
    logic [255:0] flat;
    a = int'(addr);
    if (rst) begin
      m_pgm[k] = 0; m_zed[k] = 0; m_done[k] = 0; m_pass[k] = 0; m_cnt[k] = 0;
      m_lock[k] = 0; m_err[k] = 0; m_isr[k] = 0; m_imr[k] = 1; m_irq[k] = 0;
      m_rd[k] = '0;
      return;
    end
    if (rd_en) m_rd[k] = m_read(k, a);
    if (m_cnt[k] > 0) begin
      m_cnt[k]--;
      if (m_cnt[k] == 0) begin
        m_done[k] = 1;
        m_pass[k] = (m_exp[k] == m_cap[k]);
      end
    end
    nisr = fault_evt || (m_isr[k] && !(wr_en && a == 'h38 && wdata[0]));
    if (wr_en) begin
      if (a == 'h04 && wdata[0]) m_wipe(k);
      if (a == 'h08 && wdata == 32'h757B_DF0D) begin m_wipe(k); m_pgm[k] = 1; end
      if (a == 'h0C && m_pgm[k]) begin
        for (int w = 0; w < 8; w++) flat[32*w +: 32] = m_key[k][w];
        m_cnt[k] = 9; m_done[k] = 0; m_pass[k] = 0;
        m_cap[k] = wdata; m_exp[k] = crc_of(flat);
      end
      if (a >= 'h10 && a <= 'h2C && m_pgm[k]) begin
        m_key[k][(a - 'h10) / 4] = wdata;
        if (wdata != 0) m_zed[k] = 0;
      end
      if (a == 'h30 && m_pgm[k] && !m_lock[k]) begin
        m_key[k][8] = wdata;
        if (k == 0 && wdata != 0) m_zed[k] = 0;
      end
      if (a == 'h34) m_err[k] = wdata[0];
      if (a == 'h40 && wdata[0]) m_imr[k] = 0;
      if (a == 'h44 && wdata[0]) m_imr[k] = 1;
      if (a == 'h4C && wdata[0] && k == 1) m_lock[k] = 1;
    end
    m_isr[k] = nisr;
    m_irq[k] = m_isr[k] && !m_imr[k];
  endtask

  always @(posedge clk) begin
    for (int k = 0; k < 2; k++) m_step(k);
  end

  always @(negedge clk) begin
    if (cmp_on && !finished) begin
      chk(cur_req, rdata0, m_rd[0]);
      chk(cur_req, rdata1, m_rd[1]);
      chk(cur_req, {31'b0, irq0}, {31'b0, m_irq[0]});
      chk(cur_req, {31'b0, irq1}, {31'b0, m_irq[1]});
    end
  end

  // ---------------- bus tasks ----------------
  task automatic wr(input logic [6:0] a, input logic [31:0] d, input bit ev = 1'b0);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d; fault_evt = ev;
    @(negedge clk); wr_en = 1'b0; fault_evt = 1'b0;
  endtask

  task automatic rd2(input logic [6:0] a, input logic [31:0] e0, input logic [31:0] e1,
                     input string req);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0;
    chk(req, rdata0, e0);
    chk(req, rdata1, e1);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    idle(2);
    rst = 1'b0;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  logic [255:0] pat;
  logic [31:0]  good;

  initial begin
    for (int w = 0; w < 8; w++) pat[32*w +: 32] = 32'h1357_0000 + 32'(w * 32'h0101_0011);
    good = crc_of(pat);

    idle(3);
    cmp_on = 1'b1;
    rst = 1'b0;

    cur_req = "R1";
    rd2(7'h00, 32'h0, 32'h0, "R1");
    rd2(7'h38, 32'h0, 32'h0, "R1");
    rd2(7'h3C, 32'h1, 32'h1, "R1");
    rd2(7'h4C, 32'h0, 32'h0, "R1");
    chk("R1", {31'b0, irq0}, 32'h0);

    cur_req = "R2";
    wr(7'h08, 32'h757B_DF0C);
    rd2(7'h00, 32'h0, 32'h0, "R2");
    wr(7'h08, 32'h757B_DF0D);
    rd2(7'h00, 32'h11, 32'h11, "R2");

    cur_req = "R3";
    for (int w = 0; w < 8; w++) wr(7'(16 + 4 * w), pat[32*w +: 32]);
    rd2(7'h00, 32'h01, 32'h01, "R6");
    rd2(7'h14, 32'h0, 32'h0, "R3");
    rd2(7'h0C, 32'h0, 32'h0, "R3");
    wr(7'h08, 32'h0);
    rd2(7'h00, 32'h01, 32'h01, "R2");

    cur_req = "R4";
    wr(7'h04, 32'h1);
    rd2(7'h00, 32'h11, 32'h11, "R4");
    rd2(7'h04, 32'h0, 32'h0, "R4");

    cur_req = "R6";
    wr(7'h30, 32'h55);
    rd2(7'h00, 32'h01, 32'h11, "R6");
    rd2(7'h30, 32'h0, 32'h55, "R7");

    cur_req = "R5";
    wr(7'h04, 32'h1);
    rd2(7'h30, 32'h0, 32'h55, "R5");

    cur_req = "R8";
    wr(7'h4C, 32'h1);
    rd2(7'h4C, 32'h0, 32'h1, "R8");
    wr(7'h30, 32'h77);
    rd2(7'h30, 32'h0, 32'h55, "R7");
    wr(7'h4C, 32'h0);
    rd2(7'h4C, 32'h0, 32'h1, "R8");

    cur_req = "R9";
    for (int w = 0; w < 8; w++) wr(7'(16 + 4 * w), pat[32*w +: 32]);
    wr(7'h0C, good);
    rd2(7'h00, 32'h001, 32'h001, "R9");
    idle(10);
    rd2(7'h00, 32'h301, 32'h301, "R9");
    wr(7'h0C, good ^ 32'h1);
    idle(11);
    rd2(7'h00, 32'h101, 32'h101, "R9");

    cur_req = "R10";
    wr(7'h0C, good ^ 32'h8000_0000);
    idle(2);
    wr(7'h0C, good);
    rd2(7'h00, 32'h001, 32'h001, "R10");
    idle(3);
    rd2(7'h00, 32'h001, 32'h001, "R10");
    idle(5);
    rd2(7'h00, 32'h301, 32'h301, "R10");

    cur_req = "R13";
    wr(7'h34, 32'hFFFF_FFFF);
    rd2(7'h34, 32'h1, 32'h1, "R13");
    wr(7'h34, 32'h0);
    rd2(7'h34, 32'h0, 32'h0, "R13");

    cur_req = "R11";
    @(negedge clk); fault_evt = 1'b1;
    @(negedge clk); fault_evt = 1'b0;
    rd2(7'h38, 32'h1, 32'h1, "R11");
    chk("R11", {31'b0, irq0}, 32'h0);
    wr(7'h40, 32'h1);
    chk("R11", {31'b0, irq0}, 32'h1);
    chk("R11", {31'b0, irq1}, 32'h1);
    rd2(7'h3C, 32'h0, 32'h0, "R11");
    wr(7'h38, 32'h1);
    chk("R11", {31'b0, irq0}, 32'h0);
    wr(7'h38, 32'h1, 1'b1);
    rd2(7'h38, 32'h1, 32'h1, "R11");
    chk("R11", {31'b0, irq1}, 32'h1);
    wr(7'h3C, 32'h1);
    rd2(7'h3C, 32'h0, 32'h0, "R11");
    wr(7'h44, 32'h1);
    chk("R11", {31'b0, irq0}, 32'h0);
    rd2(7'h3C, 32'h1, 32'h1, "R11");

    cur_req = "R12";
    do_reset();
    rd2(7'h00, 32'h0, 32'h0, "R12");
    rd2(7'h4C, 32'h0, 32'h0, "R12");
    rd2(7'h3C, 32'h1, 32'h1, "R12");
    rd2(7'h38, 32'h0, 32'h0, "R12");
    rd2(7'h30, 32'h0, 32'h55, "R12");
    chk("R12", {31'b0, irq0}, 32'h0);

    cur_req = "R9";
    wr(7'h0C, good);
    idle(12);
    rd2(7'h00, 32'h0, 32'h0, "R9");

    idle(2);
    summary();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      summary();
    end
  end
endmodule